// File: doc/BRIEF.md
# AXI Address and ID Access Guard

This block sits on the address path of one AXI master, between the master and the fabric. Each read and write request is looked up in a table of eight programmable rules. A rule matches when the request's ID equals the rule's ID and the request address, under the rule's compare mask, equals the rule's base. The first matching rule decides the request, and each rule gives its own permission for reads and for writes. When no rule matches, a miss policy bit decides. There is one policy bit for reads and one for writes. Their reset values are set per instance by parameters: a privileged instance denies on a miss and a guest instance passes on a miss.

A passed request goes to the fabric unchanged, and the fabric's responses come back to the master. A denied request never reaches the fabric. The guard ends it locally with an error response. A denied read gets a poisoned burst of the full requested length. A denied write has its data drained and discarded, and then gets one error response. For every denial the guard emits an interrupt pulse and bumps a saturating counter. It also latches the address of the first denial until software acknowledges it.

Top module: `axi_acl_guard`

## Requirements
- R1: A rule matches a request when the rule is enabled, `((addr ^ base) & mask) == 0` (a mask bit of 1 means that address bit is compared), and the request ID equals the rule ID. The rule's read permission applies only to reads and its write permission applies only to writes.
- R2: When several rules match, the rule with the lowest index decides.
- R3: A request that matches no rule is passed when the matching miss bit is 1 and denied when it is 0. Reads use the read miss bit and writes use the write miss bit. After reset both bits equal the parameters `RD_MISS_PASS` and `WR_MISS_PASS`, which default to 0 (deny).
- R4: A passed request is forwarded with its address, ID and length unchanged. The fabric's read data and write responses are returned to the master unchanged.
- R5: A denied request is never presented to the fabric.
- R6: A denied read returns `len+1` beats on the master side. Every beat has response 2'b10 (SLVERR), data 0xDEADBEEF repeated across the data bus, and the request's ID. RLAST is set on the final beat only.
- R7: A denied write accepts every data beat up to and including WLAST and forwards none of them. It then returns exactly one response with code 2'b10 and the request's ID.
- R8: The first denial sets `deny_vld` and records its address and direction. These stay unchanged until `deny_clr`. If a denial arrives in the same cycle as `deny_clr`, that denial is recorded.
- R9: `deny_cnt` rises by one per denied request (by two when a read and a write are denied together). It holds at all ones instead of wrapping.
- R10: `deny_irq` is high for exactly the cycle after each cycle in which a denied request is accepted.
- R11: After reset every rule is disabled, `deny_vld`, `deny_cnt` and `deny_irq` are 0, and no valid is raised toward the master or the fabric.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write the rule selected by `cfg_idx` |
| cfg_idx | input | IDX_W | Rule index |
| cfg_en | input | 1 | Rule enable |
| cfg_base | input | ADDR_W | Rule base address |
| cfg_mask | input | ADDR_W | Rule compare mask (1 = compared) |
| cfg_id | input | ID_W | Rule transaction ID |
| cfg_rd_pass | input | 1 | Rule grants reads |
| cfg_wr_pass | input | 1 | Rule grants writes |
| cfg_miss_we | input | 1 | Write the miss policy bits |
| cfg_miss_rd | input | 1 | Read miss policy (1 = pass) |
| cfg_miss_wr | input | 1 | Write miss policy (1 = pass) |
| s_arvalid | input | 1 | Master read address valid |
| s_arready | output | 1 | Master read address ready |
| s_araddr | input | ADDR_W | Master read address |
| s_arid | input | ID_W | Master read ID |
| s_arlen | input | LEN_W | Master read burst length minus one |
| s_rvalid | output | 1 | Read data valid to master |
| s_rready | input | 1 | Master read data ready |
| s_rdata | output | DATA_W | Read data to master |
| s_rid | output | ID_W | Read ID to master |
| s_rresp | output | 2 | Read response to master |
| s_rlast | output | 1 | Last read beat to master |
| s_awvalid | input | 1 | Master write address valid |
| s_awready | output | 1 | Master write address ready |
| s_awaddr | input | ADDR_W | Master write address |
| s_awid | input | ID_W | Master write ID |
| s_awlen | input | LEN_W | Master write burst length minus one |
| s_wvalid | input | 1 | Master write data valid |
| s_wready | output | 1 | Master write data ready |
| s_wdata | input | DATA_W | Master write data |
| s_wlast | input | 1 | Master last write beat |
| s_bvalid | output | 1 | Write response valid to master |
| s_bready | input | 1 | Master write response ready |
| s_bid | output | ID_W | Write response ID to master |
| s_bresp | output | 2 | Write response code to master |
| m_arvalid | output | 1 | Fabric read address valid |
| m_arready | input | 1 | Fabric read address ready |
| m_araddr | output | ADDR_W | Fabric read address |
| m_arid | output | ID_W | Fabric read ID |
| m_arlen | output | LEN_W | Fabric read length |
| m_rvalid | input | 1 | Fabric read data valid |
| m_rready | output | 1 | Fabric read data ready |
| m_rdata | input | DATA_W | Fabric read data |
| m_rid | input | ID_W | Fabric read ID |
| m_rresp | input | 2 | Fabric read response |
| m_rlast | input | 1 | Fabric last read beat |
| m_awvalid | output | 1 | Fabric write address valid |
| m_awready | input | 1 | Fabric write address ready |
| m_awaddr | output | ADDR_W | Fabric write address |
| m_awid | output | ID_W | Fabric write ID |
| m_awlen | output | LEN_W | Fabric write length |
| m_wvalid | output | 1 | Fabric write data valid |
| m_wready | input | 1 | Fabric write data ready |
| m_wdata | output | DATA_W | Fabric write data |
| m_wlast | output | 1 | Fabric last write beat |
| m_bvalid | input | 1 | Fabric write response valid |
| m_bready | output | 1 | Fabric write response ready |
| m_bid | input | ID_W | Fabric write response ID |
| m_bresp | input | 2 | Fabric write response code |
| deny_clr | input | 1 | Acknowledge the recorded denial |
| deny_vld | output | 1 | A denial is recorded |
| deny_addr | output | ADDR_W | Address of the recorded denial |
| deny_wr | output | 1 | Recorded denial was a write |
| deny_cnt | output | CNT_W | Saturating denial count |
| deny_irq | output | 1 | One-cycle pulse per denial cycle |

## Verification
The assertions assume that both the master and the fabric keep their AXI payload stable while valid waits for ready. They also assume that the master sends no write data before the matching write address has been accepted, and that the rule table and miss bits do not change while a request is waiting. The stimulus keeps within these limits. Each read or write is issued only after the previous one has completed. Write beats follow the accepted address. All rule and policy writes happen while the bus is idle. The fabric model always accepts requests and returns responses in order. Because of this, the only way the guard's outputs can differ from the reference model's predictions is through a wrong decision or a wrong local termination.

// File: rtl/axi_acl_guard.sv
module axi_acl_guard #(
  parameter int ADDR_W = 32,
  parameter int ID_W = 4,
  parameter int DATA_W = 32,
  parameter int LEN_W = 8,
  parameter int N_ENT = 8,
  parameter int CNT_W = 16,
  parameter int OUT_W = 4,
  parameter bit RD_MISS_PASS = 1'b0,
  parameter bit WR_MISS_PASS = 1'b0,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_en,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_mask,
  input  logic [ID_W-1:0]   cfg_id,
  input  logic              cfg_rd_pass,
  input  logic              cfg_wr_pass,
  input  logic              cfg_miss_we,
  input  logic              cfg_miss_rd,
  input  logic              cfg_miss_wr,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic [ID_W-1:0]   s_arid,
  input  logic [LEN_W-1:0]  s_arlen,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [ID_W-1:0]   s_rid,
  output logic [1:0]        s_rresp,
  output logic              s_rlast,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic [ID_W-1:0]   s_awid,
  input  logic [LEN_W-1:0]  s_awlen,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic              s_wlast,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [ID_W-1:0]   s_bid,
  output logic [1:0]        s_bresp,
  output logic              m_arvalid,
  input  logic              m_arready,
  output logic [ADDR_W-1:0] m_araddr,
  output logic [ID_W-1:0]   m_arid,
  output logic [LEN_W-1:0]  m_arlen,
  input  logic              m_rvalid,
  output logic              m_rready,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic [ID_W-1:0]   m_rid,
  input  logic [1:0]        m_rresp,
  input  logic              m_rlast,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic [ID_W-1:0]   m_awid,
  output logic [LEN_W-1:0]  m_awlen,
  output logic              m_wvalid,
  input  logic              m_wready,
  output logic [DATA_W-1:0] m_wdata,
  output logic              m_wlast,
  input  logic              m_bvalid,
  output logic              m_bready,
  input  logic [ID_W-1:0]   m_bid,
  input  logic [1:0]        m_bresp,
  input  logic              deny_clr,
  output logic              deny_vld,
  output logic [ADDR_W-1:0] deny_addr,
  output logic              deny_wr,
  output logic [CNT_W-1:0]  deny_cnt,
  output logic              deny_irq
);
  localparam logic [1:0] SLVERR = 2'b10;
  localparam logic [DATA_W-1:0] POISON = {(DATA_W/32){32'hDEADBEEF}};

  typedef enum logic [1:0] {W_IDLE, W_DRAIN, W_RESP} wst_t;

  logic [N_ENT-1:0]  ent_en, ent_rd, ent_wr;
  logic [ADDR_W-1:0] ent_base [N_ENT];
  logic [ADDR_W-1:0] ent_mask [N_ENT];
  logic [ID_W-1:0]   ent_id   [N_ENT];
  logic              miss_rd, miss_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_en <= '0;
      ent_rd <= '0;
      ent_wr <= '0;
      for (int i = 0; i < N_ENT; i++) begin
        ent_base[i] <= '0;
        ent_mask[i] <= '0;
        ent_id[i]   <= '0;
      end
      miss_rd <= RD_MISS_PASS;
      miss_wr <= WR_MISS_PASS;
    end else begin
      for (int i = 0; i < N_ENT; i++) begin
        if (cfg_we && cfg_idx == IDX_W'(i)) begin
          ent_en[i]   <= cfg_en;
          ent_rd[i]   <= cfg_rd_pass;
          ent_wr[i]   <= cfg_wr_pass;
          ent_base[i] <= cfg_base;
          ent_mask[i] <= cfg_mask;
          ent_id[i]   <= cfg_id;
        end
      end
      if (cfg_miss_we) begin
        miss_rd <= cfg_miss_rd;
        miss_wr <= cfg_miss_wr;
      end
    end
  end

  logic [N_ENT-1:0] ar_hit, aw_hit;
  for (genvar g = 0; g < N_ENT; g++) begin : g_match
    assign ar_hit[g] = ent_en[g] && (((s_araddr ^ ent_base[g]) & ent_mask[g]) == '0)
                       && (s_arid == ent_id[g]);
    assign aw_hit[g] = ent_en[g] && (((s_awaddr ^ ent_base[g]) & ent_mask[g]) == '0)
                       && (s_awid == ent_id[g]);
  end

  logic ar_ok, aw_ok;
  always_comb begin
    ar_ok = miss_rd;
    aw_ok = miss_wr;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (ar_hit[i]) ar_ok = ent_rd[i];
      if (aw_hit[i]) aw_ok = ent_wr[i];
    end
  end

  // read side
  logic             rd_busy;
  logic [ID_W-1:0]  rd_id;
  logic [LEN_W-1:0] rd_len, rd_beat;
  logic [OUT_W-1:0] rd_out;
  logic             ar_deny;

  assign m_arvalid = s_arvalid && ar_ok && !rd_busy && !(&rd_out);
  assign s_arready = rd_busy ? 1'b0 : (ar_ok ? (m_arready && !(&rd_out)) : (rd_out == '0));
  assign ar_deny   = s_arvalid && s_arready && !ar_ok;
  assign m_araddr  = s_araddr;
  assign m_arid    = s_arid;
  assign m_arlen   = s_arlen;

  assign s_rvalid = rd_busy ? 1'b1 : m_rvalid;
  assign s_rdata  = rd_busy ? POISON : m_rdata;
  assign s_rid    = rd_busy ? rd_id : m_rid;
  assign s_rresp  = rd_busy ? SLVERR : m_rresp;
  assign s_rlast  = rd_busy ? (rd_beat == rd_len) : m_rlast;
  assign m_rready = !rd_busy && s_rready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_busy <= 1'b0;
      rd_id   <= '0;
      rd_len  <= '0;
      rd_beat <= '0;
      rd_out  <= '0;
    end else begin
      if (ar_deny) begin
        rd_busy <= 1'b1;
        rd_id   <= s_arid;
        rd_len  <= s_arlen;
        rd_beat <= '0;
      end else if (rd_busy && s_rready) begin
        if (rd_beat == rd_len) rd_busy <= 1'b0;
        else rd_beat <= rd_beat + 1'b1;
      end
      case ({m_arvalid && m_arready, m_rvalid && m_rready && m_rlast})
        2'b10: rd_out <= rd_out + 1'b1;
        2'b01: rd_out <= rd_out - 1'b1;
        default: ;
      endcase
    end
  end

  // write side
  wst_t             wst;
  logic [ID_W-1:0]  wr_id;
  logic [OUT_W-1:0] wr_out;
  logic             aw_deny;

  assign m_awvalid = s_awvalid && aw_ok && (wst == W_IDLE) && !(&wr_out);
  assign s_awready = (wst != W_IDLE) ? 1'b0 :
                     (aw_ok ? (m_awready && !(&wr_out)) : (wr_out == '0));
  assign aw_deny   = s_awvalid && s_awready && !aw_ok;
  assign m_awaddr  = s_awaddr;
  assign m_awid    = s_awid;
  assign m_awlen   = s_awlen;

  assign m_wvalid = s_wvalid && (wst == W_IDLE);
  assign s_wready = (wst == W_DRAIN) ? 1'b1 : ((wst == W_IDLE) && m_wready);
  assign m_wdata  = s_wdata;
  assign m_wlast  = s_wlast;

  assign s_bvalid = (wst == W_RESP) ? 1'b1 : m_bvalid;
  assign s_bid    = (wst == W_RESP) ? wr_id : m_bid;
  assign s_bresp  = (wst == W_RESP) ? SLVERR : m_bresp;
  assign m_bready = (wst != W_RESP) && s_bready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wst    <= W_IDLE;
      wr_id  <= '0;
      wr_out <= '0;
    end else begin
      case (wst)
        W_IDLE:  if (aw_deny) begin wst <= W_DRAIN; wr_id <= s_awid; end
        W_DRAIN: if (s_wvalid && s_wlast) wst <= W_RESP;
        W_RESP:  if (s_bready) wst <= W_IDLE;
        default: wst <= W_IDLE;
      endcase
      case ({m_awvalid && m_awready, m_bvalid && m_bready})
        2'b10: wr_out <= wr_out + 1'b1;
        2'b01: wr_out <= wr_out - 1'b1;
        default: ;
      endcase
    end
  end

  // denial bookkeeping
  logic [CNT_W:0] cnt_sum;
  assign cnt_sum = {1'b0, deny_cnt} + (CNT_W+1)'(ar_deny) + (CNT_W+1)'(aw_deny);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deny_vld  <= 1'b0;
      deny_addr <= '0;
      deny_wr   <= 1'b0;
      deny_cnt  <= '0;
      deny_irq  <= 1'b0;
    end else begin
      deny_irq <= ar_deny || aw_deny;
      deny_cnt <= cnt_sum[CNT_W] ? '1 : cnt_sum[CNT_W-1:0];
      if (deny_clr) deny_vld <= 1'b0;
      if ((ar_deny || aw_deny) && (!deny_vld || deny_clr)) begin
        deny_vld  <= 1'b1;
        deny_addr <= ar_deny ? s_araddr : s_awaddr;
        deny_wr   <= !ar_deny;
      end
    end
  end
endmodule

module axi_acl_guard_chk #(
  parameter int ADDR_W = 32,
  parameter int ID_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_arvalid,
  input logic              s_arready,
  input logic              m_arvalid,
  input logic              s_awvalid,
  input logic              s_awready,
  input logic              m_awvalid,
  input logic              s_rvalid,
  input logic              s_rready,
  input logic [DATA_W-1:0] s_rdata,
  input logic              s_rlast,
  input logic              s_bvalid,
  input logic              s_bready,
  input logic [ID_W-1:0]   s_bid,
  input logic [1:0]        s_bresp,
  input logic              deny_clr,
  input logic              deny_vld,
  input logic [ADDR_W-1:0] deny_addr,
  input logic [CNT_W-1:0]  deny_cnt,
  input logic              deny_irq
);
  // R5
  rd_unforwarded_is_denial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_arvalid && s_arready && !m_arvalid |=> deny_irq);
  // R5
  wr_unforwarded_is_denial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_awvalid && s_awready && !m_awvalid |=> deny_irq);
  // R9
  cnt_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> deny_cnt >= $past(deny_cnt));
  // R9
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&deny_cnt) |=> (&deny_cnt));
  // R8
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deny_vld && !deny_clr |=> deny_vld && $stable(deny_addr));
  // R10
  irq_has_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deny_irq |-> deny_vld);
  // R6
  rbeat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata) && $stable(s_rlast));
  // R7
  bresp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid && $stable(s_bresp) && $stable(s_bid));
endmodule

bind axi_acl_guard axi_acl_guard_chk #(
  .ADDR_W(ADDR_W), .ID_W(ID_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .s_arvalid(s_arvalid), .s_arready(s_arready), .m_arvalid(m_arvalid),
  .s_awvalid(s_awvalid), .s_awready(s_awready), .m_awvalid(m_awvalid),
  .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rlast(s_rlast),
  .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bid(s_bid), .s_bresp(s_bresp),
  .deny_clr(deny_clr), .deny_vld(deny_vld), .deny_addr(deny_addr),
  .deny_cnt(deny_cnt), .deny_irq(deny_irq)
);

// File: tb/axi_acl_guard_test.sv
module axi_acl_guard_test;
  localparam int CW = 4;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic cfg_we = 0, cfg_en = 0, cfg_rd_pass = 0, cfg_wr_pass = 0;
  logic [2:0] cfg_idx = 0;
  logic [31:0] cfg_base = 0, cfg_mask = 0;
  logic [3:0] cfg_id = 0;
  logic cfg_miss_we = 0, cfg_miss_rd = 0, cfg_miss_wr = 0;
  logic s_arvalid = 0, s_awvalid = 0, s_wvalid = 0, s_wlast = 0;
  logic [31:0] s_araddr = 0, s_awaddr = 0, s_wdata = 0;
  logic [3:0] s_arid = 0, s_awid = 0;
  logic [7:0] s_arlen = 0, s_awlen = 0;
  logic s_rready = 1, s_bready = 1, deny_clr = 0;
  logic s_arready, s_rvalid, s_rlast, s_awready, s_wready, s_bvalid;
  logic [31:0] s_rdata;
  logic [3:0] s_rid, s_bid;
  logic [1:0] s_rresp, s_bresp;
  logic m_arvalid, m_rready, m_awvalid, m_wvalid, m_wlast, m_bready;
  logic [31:0] m_araddr, m_awaddr, m_wdata;
  logic [3:0] m_arid, m_awid;
  logic [7:0] m_arlen, m_awlen;
  logic deny_vld, deny_wr, deny_irq;
  logic [31:0] deny_addr;
  logic [CW-1:0] deny_cnt;

  // fabric model regs
  logic fr_act = 0, fb_act = 0;
  logic [31:0] fr_addr = 0;
  logic [3:0] fr_id = 0, fb_id = 0;
  logic [7:0] fr_len = 0, fr_beat = 0;
  int fwd_ar = 0, fwd_aw = 0, fwd_w = 0;
  logic [31:0] arq_addr[$];
  logic [3:0] arq_id[$], awq_id[$], bq_id[$];
  logic [7:0] arq_len[$];

  axi_acl_guard #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_base(cfg_base),
    .cfg_mask(cfg_mask), .cfg_id(cfg_id), .cfg_rd_pass(cfg_rd_pass), .cfg_wr_pass(cfg_wr_pass),
    .cfg_miss_we(cfg_miss_we), .cfg_miss_rd(cfg_miss_rd), .cfg_miss_wr(cfg_miss_wr),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr), .s_arid(s_arid),
    .s_arlen(s_arlen), .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
    .s_rid(s_rid), .s_rresp(s_rresp), .s_rlast(s_rlast),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr), .s_awid(s_awid),
    .s_awlen(s_awlen), .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata),
    .s_wlast(s_wlast), .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bid(s_bid),
    .s_bresp(s_bresp),
    .m_arvalid(m_arvalid), .m_arready(1'b1), .m_araddr(m_araddr), .m_arid(m_arid),
    .m_arlen(m_arlen), .m_rvalid(fr_act), .m_rready(m_rready), .m_rdata(fr_addr + 32'(fr_beat)),
    .m_rid(fr_id), .m_rresp(2'b00), .m_rlast(fr_beat == fr_len),
    .m_awvalid(m_awvalid), .m_awready(1'b1), .m_awaddr(m_awaddr), .m_awid(m_awid),
    .m_awlen(m_awlen), .m_wvalid(m_wvalid), .m_wready(1'b1), .m_wdata(m_wdata),
    .m_wlast(m_wlast), .m_bvalid(fb_act), .m_bready(m_bready), .m_bid(fb_id),
    .m_bresp(2'b00),
    .deny_clr(deny_clr), .deny_vld(deny_vld), .deny_addr(deny_addr), .deny_wr(deny_wr),
    .deny_cnt(deny_cnt), .deny_irq(deny_irq)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // fabric: always ready, in-order responses
  always @(posedge clk) begin
    if (!rst_n) begin
      fr_act <= 0; fb_act <= 0;
    end else begin
      if (fr_act) begin
        if (m_rready) begin
          if (fr_beat == fr_len) fr_act <= 0; else fr_beat <= fr_beat + 1;
        end
      end else if (arq_addr.size() > 0) begin
        fr_act <= 1; fr_beat <= 0;
        fr_addr <= arq_addr.pop_front(); fr_id <= arq_id.pop_front(); fr_len <= arq_len.pop_front();
      end
      if (m_arvalid) begin
        fwd_ar++; arq_addr.push_back(m_araddr); arq_id.push_back(m_arid); arq_len.push_back(m_arlen);
      end
      if (m_awvalid) begin fwd_aw++; awq_id.push_back(m_awid); end
      if (m_wvalid) begin
        fwd_w++;
        if (m_wlast) bq_id.push_back(awq_id.pop_front());
      end
      if (fb_act) begin
        if (m_bready) fb_act <= 0;
      end else if (bq_id.size() > 0) begin
        fb_act <= 1; fb_id <= bq_id.pop_front();
      end
    end
  end

  // reference rule table
  bit t_en[8], t_rd[8], t_wr[8];
  logic [31:0] t_base[8], t_mask[8];
  logic [3:0] t_id[8];
  bit t_miss_r = 0, t_miss_w = 0;

  function automatic bit tb_pass(bit wr, logic [31:0] a, logic [3:0] id);
    for (int i = 0; i < 8; i++)
      if (t_en[i] && ((a ^ t_base[i]) & t_mask[i]) == 0 && id == t_id[i])
        return wr ? t_wr[i] : t_rd[i];
    return wr ? t_miss_w : t_miss_r;
  endfunction

  // per-clock reference for counter, pulse and forwarding
  int exp_cnt = 0;
  bit exp_irq = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int n;
      #2;
      chk("R9", "deny_cnt", 64'(deny_cnt), 64'(exp_cnt));
      chk("R10", "deny_irq", 64'(deny_irq), 64'(exp_irq));
      if (m_arvalid && !(s_arvalid && tb_pass(0, s_araddr, s_arid)))
        chk("R5", "read forwarded", 1, 0);
      if (m_awvalid && !(s_awvalid && tb_pass(1, s_awaddr, s_awid)))
        chk("R5", "write forwarded", 1, 0);
      n = 0;
      if (s_arvalid && s_arready && !tb_pass(0, s_araddr, s_arid)) n++;
      if (s_awvalid && s_awready && !tb_pass(1, s_awaddr, s_awid)) n++;
      exp_irq = (n > 0);
      exp_cnt = (exp_cnt + n > (1 << CW) - 1) ? (1 << CW) - 1 : exp_cnt + n;
    end
  end

  // response monitors
  logic [31:0] rq_data[$];
  logic [3:0] rq_id[$], bm_id[$];
  logic [1:0] rq_resp[$], bm_resp[$];
  bit rq_last[$];
  always @(negedge clk) begin
    if (s_rvalid && s_rready) begin
      rq_data.push_back(s_rdata); rq_id.push_back(s_rid);
      rq_resp.push_back(s_rresp); rq_last.push_back(s_rlast);
    end
    if (s_bvalid && s_bready) begin
      bm_id.push_back(s_bid); bm_resp.push_back(s_bresp);
    end
  end

  task automatic set_rule(int idx, bit en, logic [31:0] base, logic [31:0] mask,
                          logic [3:0] id, bit rd, bit wr);
    cfg_idx = 3'(idx); cfg_en = en; cfg_base = base; cfg_mask = mask;
    cfg_id = id; cfg_rd_pass = rd; cfg_wr_pass = wr; cfg_we = 1;
    t_en[idx] = en; t_base[idx] = base; t_mask[idx] = mask; t_id[idx] = id;
    t_rd[idx] = rd; t_wr[idx] = wr;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic set_miss(bit rd, bit wr);
    cfg_miss_rd = rd; cfg_miss_wr = wr; cfg_miss_we = 1;
    t_miss_r = rd; t_miss_w = wr;
    @(negedge clk); cfg_miss_we = 0;
  endtask

  task automatic do_read(string req, logic [3:0] id, logic [31:0] addr, logic [7:0] len, bit deny);
    int f0 = fwd_ar, bad = 0, lastpos = -1, w = 0;
    rq_data.delete(); rq_id.delete(); rq_resp.delete(); rq_last.delete();
    s_arid = id; s_araddr = addr; s_arlen = len; s_arvalid = 1;
    #1;
    while (!s_arready) begin @(negedge clk); #1; end
    @(negedge clk); s_arvalid = 0;
    while (rq_data.size() < int'(len) + 1 && w < 600) begin @(negedge clk); w++; end
    repeat (2) @(negedge clk);
    chk(req, "read beats", 64'(rq_data.size()), 64'(int'(len) + 1));
    foreach (rq_data[i]) begin
      if (rq_data[i] !== (deny ? 32'hDEADBEEF : addr + 32'(i))) bad++;
      if (rq_resp[i] !== (deny ? 2'b10 : 2'b00)) bad++;
      if (rq_id[i] !== id) bad++;
      if (rq_last[i]) begin if (lastpos < 0) lastpos = i; else bad++; end
    end
    chk(req, "read beat data/resp/id errors", 64'(bad), 0);
    chk(req, "rlast position", 64'(lastpos), 64'(int'(len)));
    chk(deny ? "R5" : "R4", "reads forwarded", 64'(fwd_ar - f0), deny ? 0 : 1);
  endtask

  task automatic do_write(string req, logic [3:0] id, logic [31:0] addr, logic [7:0] len, bit deny);
    int f0 = fwd_w, w = 0;
    bm_id.delete(); bm_resp.delete();
    s_awid = id; s_awaddr = addr; s_awlen = len; s_awvalid = 1;
    #1;
    while (!s_awready) begin @(negedge clk); #1; end
    @(negedge clk); s_awvalid = 0;
    for (int b = 0; b <= int'(len); b++) begin
      s_wvalid = 1; s_wdata = 32'hA000 + 32'(b); s_wlast = (b == int'(len));
      #1;
      while (!s_wready) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    s_wvalid = 0; s_wlast = 0;
    while (bm_id.size() < 1 && w < 200) begin @(negedge clk); w++; end
    repeat (2) @(negedge clk);
    chk(req, "write responses", 64'(bm_id.size()), 1);
    if (bm_id.size() > 0) begin
      chk(req, "bresp", 64'(bm_resp[0]), deny ? 2'b10 : 2'b00);
      chk(req, "bid", 64'(bm_id[0]), 64'(id));
    end
    chk(deny ? "R7" : "R4", "write beats forwarded", 64'(fwd_w - f0), deny ? 0 : int'(len) + 1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog actual=hang expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "deny_cnt", 64'(deny_cnt), 0);
    chk("R11", "deny_vld", 64'(deny_vld), 0);
    chk("R11", "valids", 64'({s_rvalid, s_bvalid, m_arvalid, m_awvalid}), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R11", "deny_irq", 64'(deny_irq), 0);

    // R3 reset miss policy is deny; R6 / R7 local termination
    do_read("R6", 4'h1, 32'h100, 8'd3, 1);
    chk("R8", "deny_vld after first", 64'(deny_vld), 1);
    chk("R8", "deny_addr first", 64'(deny_addr), 32'h100);
    chk("R8", "deny_wr first", 64'(deny_wr), 0);
    do_write("R7", 4'h5, 32'h200, 8'd2, 1);
    chk("R8", "deny_addr holds", 64'(deny_addr), 32'h100);
    chk("R9", "two denials", 64'(deny_cnt), 2);

    // R1 separate permissions, ID and mask
    set_rule(0, 1, 32'h1000, 32'hFFFF_F000, 4'h2, 1, 0);
    do_read("R1", 4'h2, 32'h1234, 8'd1, 0);
    do_write("R1", 4'h2, 32'h1234, 8'd0, 1);
    do_read("R1", 4'h3, 32'h1234, 8'd0, 1);
    do_read("R1", 4'h2, 32'h2234, 8'd0, 1);

    // R2 lowest index wins
    set_rule(1, 1, 32'h0000_1000, 32'hFFFF_0000, 4'h2, 0, 1);
    do_read("R2", 4'h2, 32'h1010, 8'd2, 0);
    do_write("R2", 4'h2, 32'h1010, 8'd1, 1);
    do_read("R2", 4'h2, 32'h5000, 8'd0, 1);
    do_write("R2", 4'h2, 32'h5000, 8'd3, 0);

    // R8 clear then re-capture, write direction
    deny_clr = 1; @(negedge clk); deny_clr = 0;
    chk("R8", "deny_vld cleared", 64'(deny_vld), 0);
    do_write("R8", 4'h9, 32'h7700, 8'd0, 1);
    chk("R8", "recaptured addr", 64'(deny_addr), 32'h7700);
    chk("R8", "recaptured wr", 64'(deny_wr), 1);

    // R3 miss policy pass for reads only
    set_miss(1, 0);
    do_read("R3", 4'h7, 32'h9000, 8'd1, 0);
    do_write("R3", 4'h7, 32'h9000, 8'd0, 1);
    set_miss(0, 0);

    // R9 saturation
    for (int k = 0; k < 12; k++) do_read("R9", 4'h6, 32'hF000 + 32'(k), 8'd0, 1);
    chk("R9", "saturated count", 64'(deny_cnt), (1 << CW) - 1);
    chk("R8", "address held across burst of denials", 64'(deny_addr), 32'h7700);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule